// File: doc/BRIEF.md
# Predicated Saturating Vector-Scalar Adder

This unit operates on a 128-bit vector register split into lanes of 8, 16 or 32 bits. Each lane of the source vector gets a 32-bit scalar added to it or taken away from it, using the scalar's low bits at the lane width. The result is clamped to the signed or unsigned range of the lane. A 16-bit byte predicate then picks, byte by byte, whether each destination byte takes the new result or keeps the byte of the old destination vector.

A sticky saturation flag records that some lane clamped. A clamp counts only when the predicate bit of that lane's lowest byte is set; the bits of the lane's upper bytes do not matter. The flag is never cleared by an operation. A separate clear input is the only way to reset it. The result is registered and appears one cycle after a valid input.

Top module: `vsat_scalar_alu`

## Requirements
- R1: With rst_ni low, res_valid_o is 0, res_o is all zero and sat_flag_o is 0.
- R2: res_valid_o is high exactly one cycle after valid_i was high. res_o then holds the result of that operation and keeps it until the next valid operation.
- R3: Lane e spans bytes e*S to e*S+S-1, where S is 1, 2 or 4 bytes for size code 00, 01 or 10. The scalar is cut to the lane width. With sub_i=1 the lane computes lane minus scalar; with sub_i=0 it computes lane plus scalar.
- R4: With uns_i=0 (signed), each lane result is clamped to the range -2^(w-1) to 2^(w-1)-1.
- R5: With uns_i=1 (unsigned), each lane result is clamped to the range 0 to 2^w-1, so an unsigned subtract that would go below zero gives 0.
- R6: Destination byte b takes the new result when pred_i[b] is 1 and the old byte dst_i[b] when pred_i[b] is 0.
- R7: After a valid operation, sat_flag_o is set if some lane clamped and the predicate bit of that lane's lowest byte is 1. The predicate bits of the lane's upper bytes have no effect on this.
- R8: sat_flag_o is sticky. No operation clears it. It goes to 0 only in the cycle after sat_clr_i is high, and sat_clr_i takes priority over a set in the same cycle.
- R9: Size code 11 is reserved. It gives res_o equal to dst_i and leaves sat_flag_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| src_i | input | 128 | Source vector |
| dst_i | input | 128 | Old destination vector |
| scalar_i | input | 32 | Scalar operand |
| pred_i | input | 16 | Byte predicate |
| sub_i | input | 1 | 1 = subtract, 0 = add |
| uns_i | input | 1 | 1 = unsigned, 0 = signed |
| size_i | input | 2 | 00 = 8-bit, 01 = 16-bit, 10 = 32-bit, 11 = reserved |
| sat_clr_i | input | 1 | Clears the sticky flag |
| res_valid_o | output | 1 | Result valid |
| res_o | output | 128 | Merged destination vector |
| sat_flag_o | output | 1 | Sticky saturation flag |

## Verification
The assertions assume that the operation inputs are sampled only in cycles where valid_i is high, and that the inputs are stable and free of X around the clock edge. The bench drives every input from tasks half a period away from the rising edge. It holds each operation for one cycle and draws the size code only from the four defined values. Random operands are mixed with operand values at the extreme edges of each lane range, so that both clamp directions are reached at every width.

// File: rtl/vsat_pkg.sv
package vsat_pkg;
  localparam int unsigned VEC_BYTES = 16;
  localparam int unsigned VEC_W     = VEC_BYTES * 8;
  localparam int unsigned SCL_W     = 32;

  typedef enum logic [1:0] {
    SZ_B   = 2'b00,
    SZ_H   = 2'b01,
    SZ_W   = 2'b10,
    SZ_RSV = 2'b11
  } esize_e;

  typedef struct packed {
    logic   sub;
    logic   uns;
    esize_e size;
  } op_t;
endpackage

// File: rtl/vsat_lane.sv
// One lane of width EW: widened add/sub plus clamp.
module vsat_lane #(
  parameter int unsigned EW = 8
) (
  input  logic [EW-1:0] a_i,
  input  logic [EW-1:0] b_i,
  input  logic          sub_i,
  input  logic          uns_i,
  output logic [EW-1:0] y_o,
  output logic          sat_o
);
  localparam int unsigned XW = EW + 2;

  logic signed [XW-1:0] a_x, b_x, s_x;
  logic signed [XW-1:0] max_x, min_x;

  always_comb begin
    if (uns_i) begin
      a_x   = $signed({2'b00, a_i});
      b_x   = $signed({2'b00, b_i});
      max_x = $signed({2'b00, {EW{1'b1}}});
      min_x = '0;
    end else begin
      a_x   = $signed({{2{a_i[EW-1]}}, a_i});
      b_x   = $signed({{2{b_i[EW-1]}}, b_i});
      max_x = $signed({3'b000, {(EW-1){1'b1}}});
      min_x = $signed({3'b111, {(EW-1){1'b0}}});
    end
    s_x = sub_i ? (a_x - b_x) : (a_x + b_x);
    if (s_x > max_x) begin
      y_o   = max_x[EW-1:0];
      sat_o = 1'b1;
    end else if (s_x < min_x) begin
      y_o   = min_x[EW-1:0];
      sat_o = 1'b1;
    end else begin
      y_o   = s_x[EW-1:0];
      sat_o = 1'b0;
    end
  end
endmodule

// File: rtl/vsat_lane_array.sv
// All lanes for one element width; gates each lane's sat by its low predicate bit.
module vsat_lane_array #(
  parameter int unsigned VEC_BYTES = 16,
  parameter int unsigned EB        = 1
) (
  input  logic [VEC_BYTES*8-1:0] src_i,
  input  logic [31:0]            scalar_i,
  input  logic [VEC_BYTES-1:0]   pred_i,
  input  logic                   sub_i,
  input  logic                   uns_i,
  output logic [VEC_BYTES*8-1:0] res_o,
  output logic                   sat_o
);
  localparam int unsigned EW    = EB * 8;
  localparam int unsigned LANES = VEC_BYTES / EB;

  logic [LANES-1:0] lane_sat;

  for (genvar e = 0; e < LANES; e++) begin : g_lane
    logic lsat;
    vsat_lane #(.EW(EW)) u_lane (
      .a_i   (src_i[e*EW +: EW]),
      .b_i   (scalar_i[EW-1:0]),
      .sub_i (sub_i),
      .uns_i (uns_i),
      .y_o   (res_o[e*EW +: EW]),
      .sat_o (lsat)
    );
    assign lane_sat[e] = lsat & pred_i[e*EB];
  end

  assign sat_o = |lane_sat;
endmodule

// File: rtl/vsat_merge.sv
// Byte-wise predicated merge.
module vsat_merge #(
  parameter int unsigned VEC_BYTES = 16
) (
  input  logic [VEC_BYTES*8-1:0] new_i,
  input  logic [VEC_BYTES*8-1:0] old_i,
  input  logic [VEC_BYTES-1:0]   pred_i,
  output logic [VEC_BYTES*8-1:0] res_o
);
  for (genvar b = 0; b < VEC_BYTES; b++) begin : g_byte
    assign res_o[b*8 +: 8] = pred_i[b] ? new_i[b*8 +: 8] : old_i[b*8 +: 8];
  end
endmodule

// File: rtl/vsat_scalar_alu.sv
module vsat_scalar_alu
  import vsat_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [VEC_W-1:0]   src_i,
  input  logic [VEC_W-1:0]   dst_i,
  input  logic [SCL_W-1:0]   scalar_i,
  input  logic [VEC_BYTES-1:0] pred_i,
  input  logic               sub_i,
  input  logic               uns_i,
  input  logic [1:0]         size_i,
  input  logic               sat_clr_i,
  output logic               res_valid_o,
  output logic [VEC_W-1:0]   res_o,
  output logic               sat_flag_o
);
  localparam int unsigned NSZ = 3;

  op_t op;
  assign op = '{sub: sub_i, uns: uns_i, size: esize_e'(size_i)};

  logic [VEC_W-1:0] sz_res [NSZ];
  logic [NSZ-1:0]   sz_sat;

  for (genvar s = 0; s < NSZ; s++) begin : g_size
    vsat_lane_array #(.VEC_BYTES(VEC_BYTES), .EB(1 << s)) u_arr (
      .src_i    (src_i),
      .scalar_i (scalar_i),
      .pred_i   (pred_i),
      .sub_i    (op.sub),
      .uns_i    (op.uns),
      .res_o    (sz_res[s]),
      .sat_o    (sz_sat[s])
    );
  end

  logic [VEC_W-1:0]     raw_res;
  logic [VEC_BYTES-1:0] eff_pred;
  logic                 raw_sat;

  always_comb begin
    raw_res  = '0;
    raw_sat  = 1'b0;
    eff_pred = pred_i;
    unique case (op.size)
      SZ_B:   begin raw_res = sz_res[0]; raw_sat = sz_sat[0]; end
      SZ_H:   begin raw_res = sz_res[1]; raw_sat = sz_sat[1]; end
      SZ_W:   begin raw_res = sz_res[2]; raw_sat = sz_sat[2]; end
      default: eff_pred = '0;
    endcase
  end

  logic [VEC_W-1:0] merged;
  vsat_merge #(.VEC_BYTES(VEC_BYTES)) u_merge (
    .new_i  (raw_res),
    .old_i  (dst_i),
    .pred_i (eff_pred),
    .res_o  (merged)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_o       <= '0;
    end else begin
      res_valid_o <= valid_i;
      if (valid_i) res_o <= merged;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  sat_flag_o <= 1'b0;
    else if (sat_clr_i)           sat_flag_o <= 1'b0;
    else if (valid_i && raw_sat)  sat_flag_o <= 1'b1;
  end
endmodule

// File: rtl/vsat_scalar_alu_chk.sv
module vsat_scalar_alu_chk (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic [127:0] dst_i,
  input logic [15:0]  pred_i,
  input logic [1:0]   size_i,
  input logic         sat_clr_i,
  input logic         res_valid_o,
  input logic [127:0] res_o,
  input logic         sat_flag_o
);
  // R2
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> res_valid_o);
  // R2
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(res_o));
  // R8
  clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_clr_i |=> !sat_flag_o);
  // R8
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sat_flag_o && !sat_clr_i) |=> sat_flag_o);
  // R9
  rsv_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && size_i == 2'b11 && !sat_clr_i) |=> $stable(sat_flag_o));
  // R9
  rsv_res_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && size_i == 2'b11) |=> res_o == $past(dst_i));
  // R6
  nopred_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && pred_i == '0) |=> res_o == $past(dst_i));
  // R7
  noflag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && pred_i == '0 && !sat_flag_o && !sat_clr_i) |=> !sat_flag_o);
endmodule

bind vsat_scalar_alu vsat_scalar_alu_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .dst_i       (dst_i),
  .pred_i      (pred_i),
  .size_i      (size_i),
  .sat_clr_i   (sat_clr_i),
  .res_valid_o (res_valid_o),
  .res_o       (res_o),
  .sat_flag_o  (sat_flag_o)
);

// File: tb/vsat_scalar_alu_test.sv
`timescale 1ns/1ps
module vsat_scalar_alu_test;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [127:0] src_i = '0, dst_i = '0;
  logic [31:0]  scalar_i = '0;
  logic [15:0]  pred_i = '0;
  logic         sub_i = 1'b0, uns_i = 1'b0, sat_clr_i = 1'b0;
  logic [1:0]   size_i = 2'b00;
  logic         res_valid_o, sat_flag_o;
  logic [127:0] res_o;

  int n_chk = 0, n_err = 0;
  logic exp_flag = 1'b0;

  always #5 clk = ~clk;

  vsat_scalar_alu uut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .src_i(src_i),
    .dst_i(dst_i), .scalar_i(scalar_i), .pred_i(pred_i), .sub_i(sub_i),
    .uns_i(uns_i), .size_i(size_i), .sat_clr_i(sat_clr_i),
    .res_valid_o(res_valid_o), .res_o(res_o), .sat_flag_o(sat_flag_o)
  );

  function automatic void ref_model(input logic [127:0] s, d, input logic [31:0] k,
                                    input logic [15:0] p, input logic sb, un,
                                    input logic [1:0] sz,
                                    output logic [127:0] r, output logic st);
    int eb, ew;
    longint a, b, x, mx, mn;
    r = d; st = 1'b0;
    if (sz == 2'b11) return;
    eb = 1 << sz; ew = eb * 8;
    for (int e = 0; e < 16 / eb; e++) begin
      logic [31:0] av, res;
      av = 32'(s >> (e * ew));
      if (un) begin
        a = longint'(av & ((64'd1 << ew) - 1));
        b = longint'(k & ((64'd1 << ew) - 1));
        mx = (64'sd1 <<< ew) - 1; mn = 0;
      end else begin
        a = longint'(av << (32 - ew)) ; a = longint'($signed(32'(a))) >>> (32 - ew);
        b = longint'(k << (32 - ew));   b = longint'($signed(32'(b))) >>> (32 - ew);
        mx = (64'sd1 <<< (ew - 1)) - 1; mn = -(64'sd1 <<< (ew - 1));
      end
      x = sb ? a - b : a + b;
      if (x > mx) begin x = mx; if (p[e*eb]) st = 1'b1; end
      else if (x < mn) begin x = mn; if (p[e*eb]) st = 1'b1; end
      res = 32'(x);
      for (int j = 0; j < eb; j++)
        if (p[e*eb + j]) r[(e*eb + j)*8 +: 8] = res[j*8 +: 8];
    end
  endfunction

  task automatic check(input string req, input logic [127:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(input string req, input logic [127:0] s, d, input logic [31:0] k,
                        input logic [15:0] p, input logic sb, un, input logic [1:0] sz);
    logic [127:0] er; logic es;
    ref_model(s, d, k, p, sb, un, sz, er, es);
    @(negedge clk);
    src_i = s; dst_i = d; scalar_i = k; pred_i = p;
    sub_i = sb; uns_i = un; size_i = sz; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    exp_flag = exp_flag | es;
    check({req, " valid"}, {127'd0, res_valid_o}, 128'd1);
    check(req, res_o, er);
    check({req, " R7 flag"}, {127'd0, sat_flag_o}, {127'd0, exp_flag});
  endtask

  task automatic clear_flag();
    @(negedge clk); sat_clr_i = 1'b1;
    @(negedge clk); sat_clr_i = 1'b0;
    exp_flag = 1'b0;
    check("R8 clear", {127'd0, sat_flag_o}, 128'd0);
  endtask

  initial begin : watchdog
    #1500000;
    n_err++;
    $display("FAIL watchdog: got hang expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [127:0] held;
    void'($urandom(32'd1234));
    #12;
    check("R1 res", res_o, '0);
    check("R1 valid", {127'd0, res_valid_o}, '0);
    check("R1 flag", {127'd0, sat_flag_o}, '0);
    rst_ni = 1'b1;

    // R3: plain add/sub, no clamp
    run_op("R3 add b", {16{8'h10}}, '0, 32'h0000_0003, 16'hFFFF, 0, 0, 2'b00);
    run_op("R3 sub h", {8{16'h1234}}, '0, 32'hFFFF_0034, 16'hFFFF, 1, 1, 2'b01);
    // R4: signed clamp both ways
    run_op("R4 pos w", {4{32'h7FFF_FFF0}}, '0, 32'h100, 16'hFFFF, 0, 0, 2'b10);
    clear_flag();
    run_op("R4 neg b", {16{8'h80}}, '0, 32'h01, 16'hFFFF, 1, 0, 2'b00);
    clear_flag();
    // R5: unsigned clamp
    run_op("R5 under h", {8{16'h0005}}, '0, 32'h6, 16'hFFFF, 1, 1, 2'b01);
    clear_flag();
    run_op("R5 over w", {4{32'hFFFF_FFFE}}, '0, 32'h3, 16'hFFFF, 0, 1, 2'b10);
    clear_flag();
    // R6: partial merge
    run_op("R6 merge", {16{8'h01}}, {16{8'hAA}}, 32'h1, 16'hA5C3, 0, 1, 2'b00);
    // R7: upper-byte predicate only gives no flag; low byte gives flag
    run_op("R7 upper only", {4{32'hFFFF_FFFF}}, '0, 32'h1, 16'hEEEE, 0, 1, 2'b10);
    check("R7 no flag", {127'd0, sat_flag_o}, '0);
    run_op("R7 low only", {4{32'hFFFF_FFFF}}, {4{32'h1111_1111}}, 32'h1, 16'h0001, 0, 1, 2'b10);
    check("R7 flag set", {127'd0, sat_flag_o}, 128'd1);
    // R8: sticky over a non-saturating op, clear wins over a set
    run_op("R8 sticky", {16{8'h01}}, '0, 32'h1, 16'hFFFF, 0, 0, 2'b00);
    @(negedge clk);
    src_i = {16{8'hFF}}; scalar_i = 32'h1; pred_i = 16'hFFFF; sub_i = 0; uns_i = 1;
    size_i = 2'b00; valid_i = 1'b1; sat_clr_i = 1'b1;
    @(negedge clk); valid_i = 1'b0; sat_clr_i = 1'b0; exp_flag = 1'b0;
    check("R8 clear priority", {127'd0, sat_flag_o}, '0);
    // R9: reserved size
    run_op("R9 rsv", {16{8'hFF}}, {8{16'hBEEF}}, 32'h1, 16'hFFFF, 0, 1, 2'b11);
    check("R9 flag", {127'd0, sat_flag_o}, '0);
    // R2: hold when idle
    held = res_o;
    @(negedge clk); @(negedge clk);
    check("R2 hold", res_o, held);

    // random
    for (int i = 0; i < 400; i++) begin
      logic [127:0] s, d; logic [1:0] sz;
      s = {$urandom, $urandom, $urandom, $urandom};
      d = {$urandom, $urandom, $urandom, $urandom};
      sz = 2'($urandom_range(0, 3));
      if (i % 7 == 0) s = {4{32'h7F80_807F}};
      run_op("R3 R4 R5 rand", s, d, $urandom, 16'($urandom), 1'($urandom), 1'($urandom), sz);
      if (i % 50 == 49) clear_flag();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule